// File: doc/BRIEF.md
# Radio Interrupt Aggregator

This block gathers interrupt causes from a packet radio's two receive channels, its transmit path and its wake logic, and presents them as sticky status bits and one interrupt line. Each receive channel reports byte-complete, end-of-frame, overflow and underflow. The transmit path reports empty, done, overflow and underflow. A wake cause is raised when the power-down input is released. Enable masks, the operating mode and the line polarity come in as register-style levels. The status groups are read through a read port, and a per-group read strobe clears them.

Receive causes count only in receive mode, and transmit causes only in transmit mode. When both mode inputs are high, transmit wins. The stored enable masks are never changed by a mode switch, so a pending, enabled receive cause asserts the line again as soon as receive mode returns. End-of-frame is found inside the block. It counts consecutive invalid bits in each channel's per-bit valid stream after valid data has been seen, and compares the count against a programmable run length.

Top module: `radio_irq_agg`

## Requirements
- R1: An event pulse sets its status bit at the clock edge that samples it, and the bit stays set until cleared. Receive status bit 4c+k belongs to channel c, where k is 0 for full, 1 for end-of-frame, 2 for overflow and 3 for underflow. Transmit bits are 0 empty, 1 done, 2 overflow and 3 underflow.
- R2: A read strobe clears every bit of its group at the next edge. An event that arrives in the same cycle as the strobe is kept.
- R3: Receive status reads 0 unless rx_mode is 1 and tx_mode is 0. Transmit status reads 0 unless tx_mode is 1. Latched bits are kept while they are hidden and reappear when the mode returns.
- R4: In transmit mode no receive cause drives irq. The same enable mask drives irq again once receive mode returns.
- R5: irq is active when any visible status bit has its enable set. irq_act_low = 1 inverts the line, so an idle line reads 1.
- R6: For each channel, end-of-frame fires when valid data has been seen and the count of consecutive invalid bits reaches eof_len. A valid bit restarts the count. Invalid bits before any valid bit never fire. The detector fires once per frame.
- R7: An end-of-frame also sets the full bit of the same channel.
- R8: eof_len = 0 disables end-of-frame detection.
- R9: A fall of pwr_down sets wake_stat, which is always readable. wake_stat reaches irq only when wake_ien is 1.
- R10: A status bit whose enable bit is 0 does not drive irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_mode | input | 1 | Receive mode |
| tx_mode | input | 1 | Transmit mode (has priority) |
| irq_act_low | input | 1 | Selects an active-low interrupt line |
| eof_len | input | LENW (3) | End-of-frame invalid-bit run length; 0 disables |
| rx_ien | input | 4*NRX (8) | Receive cause enables |
| tx_ien | input | 4 | Transmit cause enables |
| wake_ien | input | 1 | Wake cause enable |
| rx_byte_done | input | NRX (2) | Byte complete pulse per channel |
| rx_bit_stb | input | NRX (2) | Received bit strobe per channel |
| rx_bit_vld | input | NRX (2) | Validity of the strobed bit |
| rx_ovf | input | NRX (2) | Receive overflow pulse |
| rx_unf | input | NRX (2) | Receive underflow pulse |
| tx_ev | input | 4 | Transmit event pulses |
| pwr_down | input | 1 | Power-down request |
| rd_rx_stat | input | 1 | Read strobe, receive group |
| rd_tx_stat | input | 1 | Read strobe, transmit group |
| rd_wake_stat | input | 1 | Read strobe, wake |
| rx_stat | output | 4*NRX (8) | Receive status read port |
| tx_stat | output | 4 | Transmit status read port |
| wake_stat | output | 1 | Wake status |
| irq | output | 1 | Shared interrupt line |

## Verification
The directed patterns are chosen to separate failures that look alike at the line. Single events with a matching enable, and then with a non-matching enable, test the mask. Mode flips with a pending enabled receive cause show whether the mask is preserved or was cleared. A read strobe that coincides with an event shows which of the two wins. The bit-stream patterns separate counting from the first invalid bit from counting only after valid data, and test a valid bit that restarts the count, a zero run length, and run lengths of 1 and 3. A long random phase is then compared against the bench model on every cycle, so that overlapping events, changing modes and strobes hit the paths together.

// File: rtl/radio_irq_pkg.sv
package radio_irq_pkg;
    localparam int RX_SRC  = 4;
    localparam int TX_SRC  = 4;
    localparam int RX_FULL = 0;
    localparam int RX_EOF  = 1;
    localparam int RX_OVF  = 2;
    localparam int RX_UNF  = 3;
endpackage

// File: rtl/radio_eof_det.sv
module radio_eof_det #(
    parameter int LENW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_stb,
    input  logic            bit_vld,
    input  logic [LENW-1:0] eof_len,
    output logic            eof_hit
);
    typedef struct packed {
        logic            seen;
        logic [LENW-1:0] cnt;
    } eof_st_t;

    eof_st_t st_d, st_q;
    logic [LENW:0] run_nxt;

    always_comb begin
        st_d    = st_q;
        eof_hit = 1'b0;
        run_nxt = {1'b0, st_q.cnt} + 1'b1;
        if (bit_stb) begin
            if (bit_vld) begin
                st_d.seen = 1'b1;
                st_d.cnt  = '0;
            end else if (st_q.seen && (eof_len != '0)) begin
                if (run_nxt >= {1'b0, eof_len}) begin
                    eof_hit   = 1'b1;
                    st_d.seen = 1'b0;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = run_nxt[LENW-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/radio_stat_reg.sv
module radio_stat_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         clr,
    output logic [W-1:0] q
);
    logic [W-1:0] bits_d, bits_q;

    always_comb begin
        if (clr) bits_d = set;
        else     bits_d = bits_q | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign q = bits_q;
endmodule

// File: rtl/radio_irq_agg.sv
module radio_irq_agg
    import radio_irq_pkg::*;
#(
    parameter  int NRX  = 2,
    parameter  int LENW = 3,
    localparam int RXW  = NRX * RX_SRC,
    localparam int TXW  = TX_SRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_mode,
    input  logic            tx_mode,
    input  logic            irq_act_low,
    input  logic [LENW-1:0] eof_len,
    input  logic [RXW-1:0]  rx_ien,
    input  logic [TXW-1:0]  tx_ien,
    input  logic            wake_ien,
    input  logic [NRX-1:0]  rx_byte_done,
    input  logic [NRX-1:0]  rx_bit_stb,
    input  logic [NRX-1:0]  rx_bit_vld,
    input  logic [NRX-1:0]  rx_ovf,
    input  logic [NRX-1:0]  rx_unf,
    input  logic [TXW-1:0]  tx_ev,
    input  logic            pwr_down,
    input  logic            rd_rx_stat,
    input  logic            rd_tx_stat,
    input  logic            rd_wake_stat,
    output logic [RXW-1:0]  rx_stat,
    output logic [TXW-1:0]  tx_stat,
    output logic            wake_stat,
    output logic            irq
);
    typedef struct packed {
        logic pd_prev;
        logic wake;
    } wake_st_t;

    logic [RXW-1:0] rx_set, rx_lat;
    logic [TXW-1:0] tx_lat;
    logic           rx_live, tx_live, irq_raw;
    wake_st_t       wk_d, wk_q;

    for (genvar c = 0; c < NRX; c++) begin : g_ch
        logic eof_hit;
        radio_eof_det #(.LENW(LENW)) u_eof (
            .clk     (clk),
            .rst_n   (rst_n),
            .bit_stb (rx_bit_stb[c]),
            .bit_vld (rx_bit_vld[c]),
            .eof_len (eof_len),
            .eof_hit (eof_hit)
        );
        assign rx_set[c*RX_SRC+RX_FULL] = rx_byte_done[c] | eof_hit;
        assign rx_set[c*RX_SRC+RX_EOF]  = eof_hit;
        assign rx_set[c*RX_SRC+RX_OVF]  = rx_ovf[c];
        assign rx_set[c*RX_SRC+RX_UNF]  = rx_unf[c];
    end

    radio_stat_reg #(.W(RXW)) u_rx_stat (
        .clk (clk), .rst_n (rst_n), .set (rx_set), .clr (rd_rx_stat), .q (rx_lat)
    );

    radio_stat_reg #(.W(TXW)) u_tx_stat (
        .clk (clk), .rst_n (rst_n), .set (tx_ev), .clr (rd_tx_stat), .q (tx_lat)
    );

    always_comb begin
        wk_d         = wk_q;
        wk_d.pd_prev = pwr_down;
        if (rd_wake_stat) wk_d.wake = 1'b0;
        if (wk_q.pd_prev && !pwr_down) wk_d.wake = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_q.pd_prev <= pwr_down;
            wk_q.wake    <= 1'b0;
        end else begin
            wk_q <= wk_d;
        end
    end

    assign tx_live   = tx_mode;
    assign rx_live   = rx_mode & ~tx_mode;
    assign rx_stat   = rx_live ? rx_lat : '0;
    assign tx_stat   = tx_live ? tx_lat : '0;
    assign wake_stat = wk_q.wake;

    assign irq_raw = (|(rx_stat & rx_ien)) | (|(tx_stat & tx_ien)) | (wake_stat & wake_ien);
    assign irq     = irq_raw ^ irq_act_low;
endmodule

// File: rtl/radio_irq_agg_chk.sv
module radio_irq_agg_chk #(
    parameter int RXW  = 8,
    parameter int TXW  = 4,
    parameter int LENW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rx_mode,
    input logic            tx_mode,
    input logic            irq_act_low,
    input logic [LENW-1:0] eof_len,
    input logic [RXW-1:0]  rx_ien,
    input logic [TXW-1:0]  tx_ien,
    input logic            wake_ien,
    input logic            rx_byte_done0,
    input logic [TXW-1:0]  tx_ev,
    input logic            pwr_down,
    input logic            rd_rx_stat,
    input logic            rd_tx_stat,
    input logic [RXW-1:0]  rx_stat,
    input logic [TXW-1:0]  tx_stat,
    input logic            wake_stat,
    input logic            irq
);
    logic rx_on;
    assign rx_on = rx_mode & ~tx_mode;

    assert_byte_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_on && rx_byte_done0) ##1 rx_on |-> rx_stat[0]);

    assert_read_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_tx_stat && tx_ev == '0) |=> tx_stat == '0);

    assert_rx_hidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_mode |-> rx_stat == '0);

    assert_tx_hidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_mode |-> tx_stat == '0);

    assert_idle_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ien == '0 && tx_ien == '0 && !wake_ien) |-> irq == irq_act_low);

    assert_no_eof_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_on && eof_len == '0 && !rd_rx_stat) ##1 rx_on |-> !$rose(rx_stat[1]));

    assert_wake_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_down) && !pwr_down) |=> wake_stat);
endmodule

bind radio_irq_agg radio_irq_agg_chk #(.RXW(RXW), .TXW(TXW), .LENW(LENW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_mode       (rx_mode),
    .tx_mode       (tx_mode),
    .irq_act_low   (irq_act_low),
    .eof_len       (eof_len),
    .rx_ien        (rx_ien),
    .tx_ien        (tx_ien),
    .wake_ien      (wake_ien),
    .rx_byte_done0 (rx_byte_done[0]),
    .tx_ev         (tx_ev),
    .pwr_down      (pwr_down),
    .rd_rx_stat    (rd_rx_stat),
    .rd_tx_stat    (rd_tx_stat),
    .rx_stat       (rx_stat),
    .tx_stat       (tx_stat),
    .wake_stat     (wake_stat),
    .irq           (irq)
);

// File: tb/sim_radio_irq_agg.sv
module sim_radio_irq_agg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_mode = 0, tx_mode = 0, irq_act_low = 0, wake_ien = 0;
    logic [2:0] eof_len = 0;
    logic [7:0] rx_ien = 0;
    logic [3:0] tx_ien = 0, tx_ev = 0;
    logic [1:0] rx_byte_done = 0, rx_bit_stb = 0, rx_bit_vld = 0, rx_ovf = 0, rx_unf = 0;
    logic       pwr_down = 0, rd_rx_stat = 0, rd_tx_stat = 0, rd_wake_stat = 0;
    logic [7:0] rx_stat;
    logic [3:0] tx_stat;
    logic       wake_stat, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    radio_irq_agg u0 (
        .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .tx_mode(tx_mode),
        .irq_act_low(irq_act_low), .eof_len(eof_len), .rx_ien(rx_ien), .tx_ien(tx_ien),
        .wake_ien(wake_ien), .rx_byte_done(rx_byte_done), .rx_bit_stb(rx_bit_stb),
        .rx_bit_vld(rx_bit_vld), .rx_ovf(rx_ovf), .rx_unf(rx_unf), .tx_ev(tx_ev),
        .pwr_down(pwr_down), .rd_rx_stat(rd_rx_stat), .rd_tx_stat(rd_tx_stat),
        .rd_wake_stat(rd_wake_stat), .rx_stat(rx_stat), .tx_stat(tx_stat),
        .wake_stat(wake_stat), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference model
    logic [7:0] m_rx, ev_rx;
    logic [3:0] m_tx;
    logic       m_wk, m_prev;
    int         seen [2];
    int         runc [2];
    bit         hit;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rx = 0; m_tx = 0; m_wk = 0; m_prev = pwr_down;
            seen[0] = 0; seen[1] = 0; runc[0] = 0; runc[1] = 0;
        end else begin
            ev_rx = 0;
            for (int c = 0; c < 2; c++) begin
                hit = 0;
                if (rx_bit_stb[c]) begin
                    if (rx_bit_vld[c]) begin
                        seen[c] = 1; runc[c] = 0;
                    end else if (seen[c] != 0 && eof_len != 0) begin
                        runc[c] = runc[c] + 1;
                        if (runc[c] >= int'(eof_len)) begin
                            hit = 1; seen[c] = 0; runc[c] = 0;
                        end
                    end
                end
                ev_rx[c*4+0] = rx_byte_done[c] | hit;
                ev_rx[c*4+1] = hit;
                ev_rx[c*4+2] = rx_ovf[c];
                ev_rx[c*4+3] = rx_unf[c];
            end
            m_rx = rd_rx_stat ? ev_rx : (m_rx | ev_rx);
            m_tx = rd_tx_stat ? tx_ev : (m_tx | tx_ev);
            if (rd_wake_stat) m_wk = 0;
            if (m_prev && !pwr_down) m_wk = 1;
            m_prev = pwr_down;
        end
    end

    logic [7:0] e_rx;
    logic [3:0] e_tx;
    logic       e_irq;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            e_rx  = (rx_mode && !tx_mode) ? m_rx : 8'h00;
            e_tx  = tx_mode ? m_tx : 4'h0;
            e_irq = ((e_rx & rx_ien) != 0) || ((e_tx & tx_ien) != 0) || (m_wk && wake_ien);
            e_irq = e_irq ^ irq_act_low;
            chk("R3 rx_stat model", rx_stat, e_rx);
            chk("R3 tx_stat model", tx_stat, e_tx);
            chk("R9 wake_stat model", wake_stat, m_wk);
            chk("R5 irq model", irq, e_irq);
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic rbit(input int ch, input logic v);
        rx_bit_stb[ch] = 1'b1;
        rx_bit_vld[ch] = v;
        tick();
        rx_bit_stb = 0;
        rx_bit_vld = 0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) tick();
        rst_n = 1;
        tick();
        chk("R1 reset rx", rx_stat, 0);
        chk("R1 reset tx", tx_stat, 0);
        chk("R9 reset wake", wake_stat, 0);
        chk("R5 reset irq", irq, 0);

        rx_mode = 1; rx_ien = 8'h01; tick();
        rx_byte_done = 2'b01; tick(); rx_byte_done = 0;
        chk("R1 full A set", rx_stat, 8'h01);
        chk("R5 irq on enabled full", irq, 1);
        rx_ien = 8'hFE; tick();
        chk("R10 masked full", irq, 0);
        rx_ien = 8'h40;
        rd_rx_stat = 1; tick(); rd_rx_stat = 0;
        chk("R2 read clears", rx_stat, 0);
        rd_rx_stat = 1; rx_ovf = 2'b10; tick(); rd_rx_stat = 0; rx_ovf = 0;
        chk("R2 event beats read", rx_stat, 8'h40);
        tx_mode = 1; tick();
        chk("R3 rx hidden in tx", rx_stat, 0);
        chk("R4 rx irq gated in tx", irq, 0);
        tx_mode = 0; tick();
        chk("R3 rx kept", rx_stat, 8'h40);
        chk("R4 enable kept", irq, 1);
        rd_rx_stat = 1; tick(); rd_rx_stat = 0;

        rx_mode = 0; tx_mode = 1; tx_ien = 4'b0010;
        tx_ev = 4'b0010; tick(); tx_ev = 0;
        chk("R1 tx done set", tx_stat, 4'h2);
        chk("R5 tx irq", irq, 1);
        tx_mode = 0; tick();
        chk("R3 tx hidden", tx_stat, 0);
        chk("R5 irq off outside tx", irq, 0);
        tx_mode = 1; rd_tx_stat = 1; tick(); rd_tx_stat = 0;
        chk("R2 tx read clears", tx_stat, 0);

        tx_mode = 0; rx_mode = 1; rx_ien = 0; eof_len = 3;
        for (int i = 0; i < 4; i++) rbit(0, 0);
        chk("R6 no eof before valid", rx_stat, 0);
        rbit(0, 1); rbit(0, 0); rbit(0, 0);
        rbit(0, 1); rbit(0, 0); rbit(0, 0);
        chk("R6 valid restarts run", rx_stat, 0);
        rbit(0, 0);
        chk("R7 eof sets eof and full", rx_stat, 8'h03);
        rd_rx_stat = 1; tick(); rd_rx_stat = 0;
        for (int i = 0; i < 5; i++) rbit(0, 0);
        chk("R6 once per frame", rx_stat, 0);
        eof_len = 0;
        rbit(1, 1);
        for (int i = 0; i < 9; i++) rbit(1, 0);
        chk("R8 length zero disables", rx_stat, 0);
        eof_len = 1;
        rbit(1, 0);
        chk("R6 channel B length one", rx_stat, 8'h30);
        rd_rx_stat = 1; tick(); rd_rx_stat = 0;

        pwr_down = 1; tick();
        chk("R9 no wake on assert", wake_stat, 0);
        pwr_down = 0; tick(); tick();
        chk("R9 wake on release", wake_stat, 1);
        chk("R9 wake masked", irq, 0);
        wake_ien = 1; tick();
        chk("R9 wake enabled", irq, 1);
        rd_wake_stat = 1; tick(); rd_wake_stat = 0;
        chk("R2 wake read clears", wake_stat, 0);
        irq_act_low = 1; tick();
        chk("R5 active low idle", irq, 1);
        pwr_down = 1; tick(); pwr_down = 0; tick(); tick();
        chk("R5 active low asserted", irq, 0);

        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 40) == 0) rx_mode = ~rx_mode;
            if ($urandom_range(0, 40) == 0) tx_mode = ~tx_mode;
            if ($urandom_range(0, 60) == 0) irq_act_low = ~irq_act_low;
            if ($urandom_range(0, 50) == 0) eof_len = 3'($urandom);
            if ($urandom_range(0, 30) == 0) begin
                rx_ien = 8'($urandom); tx_ien = 4'($urandom); wake_ien = 1'($urandom);
            end
            rx_byte_done = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00;
            rx_ovf       = ($urandom_range(0, 15) == 0) ? 2'($urandom) : 2'b00;
            rx_unf       = ($urandom_range(0, 15) == 0) ? 2'($urandom) : 2'b00;
            tx_ev        = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
            rx_bit_stb   = 2'($urandom);
            rx_bit_vld   = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00;
            if ($urandom_range(0, 20) == 0) pwr_down = ~pwr_down;
            rd_rx_stat   = ($urandom_range(0, 9) == 0);
            rd_tx_stat   = ($urandom_range(0, 9) == 0);
            rd_wake_stat = ($urandom_range(0, 9) == 0);
            tick();
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule